// File: doc/BRIEF.md
# Incremental Encoder Position Decoder with Index Capture

This block turns the two quadrature phases of one incremental encoder into a signed position count. The phases and an active-low index input are first passed through a synchronizer on the fast clock. They are then sampled once every `DIV` fast clocks, which is one quarter of the master rate by default. Each legal change of the two-phase state between consecutive samples moves the count by one, so the count runs at four times the line resolution.

A sample in which both phases have changed cannot be resolved into a direction. Such a sample leaves the count alone and raises an error flag that stays set until reset. The block qualifies the index only when both phases read low together with the index input. On the first sample of each qualified episode it copies the count into a capture register and raises a valid flag. A one-cycle read strobe clears that flag.

A separate consumer reads the count and the captured value, for example to compare them against the commanded step position.

Top module: `qdec_axis`

## Requirements
- R1: While reset is applied and right after it, position reads 0, count_err reads 0, cap_valid reads 0 and cap_pos reads 0.
- R2: Inputs pass through a two-stage synchronizer. They are acted upon only at sample points that occur once every DIV (default 4) clocks, so position, count_err and the capture outputs change only on the clock that follows a sample point (apart from the read-driven clear of cap_valid).
- R3: Forward motion, with phase_a leading phase_b so that the state {phase_a,phase_b} steps 00→10→11→01→00, adds 1 to position for each state change seen at a sample point.
- R4: Reverse motion, with the state stepping 00→01→11→10→00, subtracts 1 from position for each state change seen at a sample point.
- R5: If both phases differ from the previous sample, position is left unchanged and count_err is set. count_err then stays at 1 until reset.
- R6: The first sample point after reset only records the phase state. It never changes position, whatever the phases read.
- R7: A qualified index is a sample with phase_a=0, phase_b=0 and index_n=0. On the first qualified sample after one that was not qualified, cap_pos takes the position value produced by that same sample. A qualified index held over later samples does not capture again.
- R8: A capture sets cap_valid. A cap_read pulse clears cap_valid on the next clock. A capture in the same cycle as a read wins, and cap_valid stays 1.
- R9: position is a POS_W-bit (default 32) two's-complement value that wraps modulo 2^POS_W, so one reverse step from 0 reads all ones.
- R10: Samples with no change in the phase state leave position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_n | input | 1 | Encoder index, active low, asynchronous |
| cap_read | input | 1 | One-cycle strobe that clears cap_valid |
| position | output | POS_W | Signed position count |
| count_err | output | 1 | Sticky flag for an unresolvable double-phase change |
| cap_pos | output | POS_W | Position latched at the last qualified index |
| cap_valid | output | 1 | A capture has occurred since the last read |

## Verification
The phases are driven through whole forward cycles and whole reverse cycles. Forward cycles show that the direction sense is right. Reverse cycles that take the count below zero show the decrement and the wraparound. The first sample after reset is taken with both phases high, which tells a correct priming apart from a spurious count.

The index is asserted at state 00 and also at a non-zero phase state. This separates the qualification from the raw index, and holding the index low across a read shows that there is one capture per episode. A jump straight from 00 to 11 produces the double-change error, and forward steps after it confirm that the flag is sticky while counting continues.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  typedef struct packed {
    logic a;
    logic b;
    logic idx_n;
  } qsig_t;

  localparam int QSIG_W = $bits(qsig_t);

endpackage

// File: rtl/qdec_rst_sync.sv
module qdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] rst_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_core_n = rst_pipe[1];

endmodule

// File: rtl/qdec_tick.sv
module qdec_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign q[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic [1:0] prev_ab,
  input  logic [1:0] cur_ab,
  output step_e      step
);

  logic [1:0] flip;

  always_comb begin
    flip = prev_ab ^ cur_ab;
    unique case (flip)
      2'b00:   step = STEP_NONE;
      2'b11:   step = STEP_BAD;
      default: step = (cur_ab[1] != prev_ab[0]) ? STEP_UP : STEP_DOWN;
    endcase
  end

endmodule

// File: rtl/qdec_axis.sv
module qdec_axis
  import qdec_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_n,
  input  logic             cap_read,
  output logic [POS_W-1:0] position,
  output logic             count_err,
  output logic [POS_W-1:0] cap_pos,
  output logic             cap_valid
);

  localparam logic [POS_W-1:0] ONE     = POS_W'(1);
  localparam logic [QSIG_W-1:0] SYN_RST = QSIG_W'(1);

  logic rst_core_n;
  logic samp_tick;
  qsig_t raw_sig, syn_sig;
  logic [QSIG_W-1:0] syn_vec;
  step_e step;

  logic [1:0]       prev_ab_q, prev_ab_d;
  logic             primed_q, primed_d;
  logic             idx_q, idx_d;
  logic [POS_W-1:0] pos_d, cap_pos_d;
  logic             err_d, capv_d;
  logic             qual;

  qdec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  qdec_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (samp_tick)
  );

  assign raw_sig = '{a: phase_a, b: phase_b, idx_n: index_n};

  qdec_sync #(.W(QSIG_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (raw_sig),
    .q     (syn_vec)
  );

  assign syn_sig = qsig_t'(syn_vec);

  qdec_step u_step (
    .prev_ab (prev_ab_q),
    .cur_ab  ({syn_sig.a, syn_sig.b}),
    .step    (step)
  );

  always_comb begin
    qual      = ~syn_sig.a & ~syn_sig.b & ~syn_sig.idx_n;
    prev_ab_d = prev_ab_q;
    primed_d  = primed_q;
    idx_d     = idx_q;
    pos_d     = position;
    err_d     = count_err;
    cap_pos_d = cap_pos;
    capv_d    = cap_valid;
    if (cap_read) capv_d = 1'b0;
    if (samp_tick) begin
      prev_ab_d = {syn_sig.a, syn_sig.b};
      primed_d  = 1'b1;
      idx_d     = qual;
      if (primed_q) begin
        unique case (step)
          STEP_UP:   pos_d = position + ONE;
          STEP_DOWN: pos_d = position - ONE;
          STEP_BAD:  err_d = 1'b1;
          default:   pos_d = position;
        endcase
        if (qual && !idx_q) begin
          cap_pos_d = pos_d;
          capv_d    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      prev_ab_q <= 2'b00;
      primed_q  <= 1'b0;
      idx_q     <= 1'b0;
      position  <= '0;
      count_err <= 1'b0;
      cap_pos   <= '0;
      cap_valid <= 1'b0;
    end else begin
      prev_ab_q <= prev_ab_d;
      primed_q  <= primed_d;
      idx_q     <= idx_d;
      position  <= pos_d;
      count_err <= err_d;
      cap_pos   <= cap_pos_d;
      cap_valid <= capv_d;
    end
  end

endmodule

// File: rtl/qdec_axis_chk.sv
module qdec_axis_chk #(
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [POS_W-1:0] position,
  input logic             count_err,
  input logic             cap_valid,
  input logic             cap_read
);

  // R3 / R4: a change of position is always a single count
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (position != $past(position)) |->
      ((position - $past(position)) == POS_W'(1) || ($past(position) - position) == POS_W'(1)));

  // R2: position only moves on the clock after a sample point
  a_r2_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (position != $past(position)) |-> $past(tick));

  // R5: error flag is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(count_err) |-> count_err);

  // R5: the sample that raises the error does not count
  a_r5_freeze_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_err) |-> $stable(position));

  // R8: cap_valid only falls after a read
  a_r8_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_valid) |-> $past(cap_read));

  // R7: captures happen only at sample points
  a_r7_cap_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_valid) |-> $past(tick));

endmodule

bind qdec_axis qdec_axis_chk #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (samp_tick),
  .position  (position),
  .count_err (count_err),
  .cap_valid (cap_valid),
  .cap_read  (cap_read)
);

// File: tb/test_qdec_axis.sv
`timescale 1ns/1ps
module test_qdec_axis;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic phase_a = 1'b1, phase_b = 1'b1, index_n = 1'b1, cap_read = 1'b0;
  logic [31:0] position, cap_pos;
  logic count_err, cap_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qdec_axis i_qdec_axis (
    .clk, .rst_n, .phase_a, .phase_b, .index_n, .cap_read,
    .position, .count_err, .cap_pos, .cap_valid
  );

  // ---------------- reference model ----------------
  logic [2:0]  sq[$];
  int          mrel, mcnt;
  bit          mprimed, midx;
  logic [1:0]  mprev;
  logic [31:0] mpos, mcap;
  bit          merr, mcapv;
  logic [2:0]  mcur;
  bit          mqual;

  function automatic int gidx(logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic mreset();
    sq = '{3'b001, 3'b001};
    mcnt = 0; mprimed = 0; midx = 0; mprev = 2'b00;
    mpos = 0; mcap = 0; merr = 0; mcapv = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrel = 0; mreset();
    end else if (mrel < 2) begin
      mrel++; mreset();
    end else begin
      mcur = sq[0];
      void'(sq.pop_front());
      sq.push_back({phase_a, phase_b, index_n});
      if (cap_read) mcapv = 0;
      if (mcnt == 3) begin
        mqual = (mcur == 3'b000);
        if (mprimed) begin
          case ((gidx(mcur[2:1]) - gidx(mprev) + 4) % 4)
            1: mpos = mpos + 1;
            3: mpos = mpos - 1;
            2: merr = 1;
            default: ;
          endcase
          if (mqual && !midx) begin mcap = mpos; mcapv = 1; end
        end
        mprev = mcur[2:1]; mprimed = 1; midx = mqual;
      end
      mcnt = (mcnt + 1) % 4;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 timing, R3/R4 counting, R5, R7, R8)
  always @(negedge clk) begin
    chk("R2 position vs model", position, mpos);
    chk("R5 count_err vs model", {31'b0, count_err}, {31'b0, merr});
    chk("R7 cap_pos vs model", cap_pos, mcap);
    chk("R8 cap_valid vs model", {31'b0, cap_valid}, {31'b0, mcapv});
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ab(logic a, logic b);
    @(negedge clk); phase_a = a; phase_b = b;
    wait_cyc(8);
  endtask

  task automatic fwd(int n);
    for (int i = 0; i < n; i++) begin
      case ({phase_a, phase_b})
        2'b00: set_ab(1, 0);
        2'b10: set_ab(1, 1);
        2'b11: set_ab(0, 1);
        default: set_ab(0, 0);
      endcase
    end
  endtask

  task automatic rev(int n);
    for (int i = 0; i < n; i++) begin
      case ({phase_a, phase_b})
        2'b00: set_ab(0, 1);
        2'b01: set_ab(1, 1);
        2'b11: set_ab(1, 0);
        default: set_ab(0, 0);
      endcase
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    wait_cyc(4);
    chk("R1 position in reset", position, 32'h0);
    chk("R1 cap_valid in reset", {31'b0, cap_valid}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(20);
    chk("R1 count_err after reset", {31'b0, count_err}, 32'h0);
    chk("R1 cap_pos after reset", cap_pos, 32'h0);
    chk("R6 first sample at 11 does not count", position, 32'h0);

    fwd(8);
    chk("R3 eight forward steps", position, 32'd8);
    wait_cyc(30);
    chk("R10 idle keeps position", position, 32'd8);

    rev(10);
    chk("R4 R9 ten reverse steps wrap below zero", position, 32'hFFFF_FFFE);

    @(negedge clk) index_n = 1'b0;
    wait_cyc(8);
    chk("R7 capture at state 00", cap_pos, 32'hFFFF_FFFE);
    chk("R8 cap_valid set by capture", {31'b0, cap_valid}, 32'h1);
    @(negedge clk) cap_read = 1'b1;
    @(negedge clk) cap_read = 1'b0;
    wait_cyc(12);
    chk("R7 R8 held index does not recapture after read", {31'b0, cap_valid}, 32'h0);
    @(negedge clk) index_n = 1'b1;

    fwd(2);
    @(negedge clk) index_n = 1'b0;
    wait_cyc(12);
    chk("R7 index ignored away from 00", {31'b0, cap_valid}, 32'h0);
    @(negedge clk) index_n = 1'b1;
    fwd(2);
    @(negedge clk) index_n = 1'b0;
    wait_cyc(8);
    chk("R7 capture value after new motion", cap_pos, 32'd2);
    @(negedge clk) index_n = 1'b1;

    set_ab(1, 1);
    chk("R5 double change leaves count", position, 32'd2);
    chk("R5 double change raises error", {31'b0, count_err}, 32'h1);
    fwd(1);
    chk("R5 counting continues after error", position, 32'd3);
    chk("R5 error stays set", {31'b0, count_err}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule